// File: doc/BRIEF.md
# Timed Serial Frame Serializer

This block is a transmit-only serial bus master. Once enabled, it sends frames back to back on a data line. Each frame is 4 to 32 bits long and is framed by an active-low select. The data line is shifted against a divided serial clock. The word for a frame comes from one of two sources, chosen by a control bit:

- a 32-bit alternate data register that the host writes;
- a snapshot of 32 parallel input pins, taken on the system clock edge that starts the frame.

Between frames the select stays high for a programmable number of whole serial clock periods, never fewer than one. The serial clock has a configurable idle level. It can either keep toggling through the gaps between frames or rest at its idle level whenever no bits are being shifted.

The host configures the block through a small write-only register port. Address 0 holds the control word and address 1 holds the alternate data word. A one-cycle frame-done pulse marks the end of every frame.

Top module: `tsb_serializer`

## Requirements
- R1: After a synchronous reset, `cs_n` is 1, `sck` is 0, `sout` is 0 and `frame_done` is 0, and no frame starts until the host sets the run bit.
- R2: A write to address 0 loads the control word: bit 0 run, bit 1 source, bit 2 continuous clock, bit 3 clock polarity, bits 11:4 frame length, bits 21:12 gap periods, bits 31:22 half-period in system clocks. A write to address 1 loads the alternate data word, which is the frame source when the source bit is 0.
- R3: A length field below 4 gives 4-bit frames and a length field above 32 gives 32-bit frames; values from 4 to 32 are used as written.
- R4: Each frame sends bits length-1 down to 0 of its word, most significant first. Word bits at or above the length never appear on `sout`.
- R5: When the source bit is 1, the frame word is the value of `par_in` at the system clock edge where `cs_n` falls. Later changes of `par_in` do not alter that frame.
- R6: One serial clock period is 2 x half-period system clocks, and a half-period field of 0 acts as 1. `cs_n` stays low for exactly length x period system clocks.
- R7: When `cs_n` falls, `sck` is at its idle level. Each bit is placed on `sout` at the start of its period and is held through the leading edge, which comes half a period later.
- R8: Between two consecutive frames, `cs_n` is high for exactly gap x period system clocks. A gap field of 0 acts as 1.
- R9: With the continuous bit set, `sck` makes one leading edge in every gap period.
- R10: With the continuous bit clear, `sck` rests at its idle level whenever `cs_n` is high.
- R11: The idle level of `sck` equals the polarity bit: low when it is 0 and high when it is 1.
- R12: Clearing the run bit during a frame lets that frame and its full gap complete. After that, no further frame starts and `sck` rests at its idle level.
- R13: `frame_done` is high for exactly one system clock, in the first cycle that `cs_n` is high after a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 alternate data |
| reg_wdata | input | 32 | Register write data |
| par_in | input | 32 | Parallel inputs sampled as a frame source |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data, most significant bit first |
| cs_n | output | 1 | Active-low frame select |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The hardest situation to reach from the ports is a stop request that arrives inside a frame. The frame must still finish, and the gap after it must run its full length before the block goes quiet. The only visible evidence of that gap is the serial clock in continuous mode. The stimulus therefore observes a frame in one thread while a second thread clears the run bit in the middle of it. The bench then counts the leading edges that follow the frame and checks that no further select is asserted.

The parallel-pin snapshot is the second hard case. To test it, the stimulus changes the pins on the first sample where the select is low. That frame must still carry the old value, and the next frame must carry the new one.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    localparam int WORD_W      = 32;
    localparam int LEN_W       = $clog2(WORD_W + 1);
    localparam int LEN_FLD_W   = 8;
    localparam int GAP_W       = 10;
    localparam int HALF_W      = 10;
    localparam int MIN_LEN     = 4;
    localparam int REG_ADDR_W  = 1;

    // control word layout
    localparam int F_RUN     = 0;
    localparam int F_SRC     = 1;
    localparam int F_CONT    = 2;
    localparam int F_CPOL    = 3;
    localparam int F_LEN_LO  = 4;
    localparam int F_GAP_LO  = F_LEN_LO + LEN_FLD_W;
    localparam int F_HALF_LO = F_GAP_LO + GAP_W;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = '0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic              run;
        logic              src_pins;
        logic              cont;
        logic              cpol;
        logic [LEN_W-1:0]  len;
        logic [GAP_W-1:0]  gap;
        logic [HALF_W-1:0] half;
    } tsb_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_FLD_W-1:0] raw);
        if (raw < LEN_FLD_W'(MIN_LEN))
            return LEN_W'(MIN_LEN);
        else if (raw > LEN_FLD_W'(WORD_W))
            return LEN_W'(WORD_W);
        else
            return raw[LEN_W-1:0];
    endfunction

    function automatic logic [GAP_W-1:0] at_least_one_gap(input logic [GAP_W-1:0] raw);
        return (raw == '0) ? GAP_W'(1) : raw;
    endfunction

    function automatic logic [HALF_W-1:0] at_least_one_half(input logic [HALF_W-1:0] raw);
        return (raw == '0) ? HALF_W'(1) : raw;
    endfunction

endpackage

// File: rtl/tsb_regs.sv
module tsb_regs
    import tsb_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WW-1:0]         wdata,
    output tsb_cfg_t              cfg,
    output logic [WW-1:0]         alt_word
);

    tsb_cfg_t      cfg_q;
    logic [WW-1:0] alt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.run      <= 1'b0;
            cfg_q.src_pins <= 1'b0;
            cfg_q.cont     <= 1'b0;
            cfg_q.cpol     <= 1'b0;
            cfg_q.len      <= LEN_W'(MIN_LEN);
            cfg_q.gap      <= GAP_W'(1);
            cfg_q.half     <= HALF_W'(1);
            alt_q          <= '0;
        end else if (we) begin
            if (addr == ADDR_CTRL) begin
                cfg_q.run      <= wdata[F_RUN];
                cfg_q.src_pins <= wdata[F_SRC];
                cfg_q.cont     <= wdata[F_CONT];
                cfg_q.cpol     <= wdata[F_CPOL];
                cfg_q.len      <= clamp_len(wdata[F_LEN_LO +: LEN_FLD_W]);
                cfg_q.gap      <= at_least_one_gap(wdata[F_GAP_LO +: GAP_W]);
                cfg_q.half     <= at_least_one_half(wdata[F_HALF_LO +: HALF_W]);
            end else begin
                alt_q <= wdata;
            end
        end
    end

    assign cfg      = cfg_q;
    assign alt_word = alt_q;

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.len >= LEN_W'(MIN_LEN)) && (cfg_q.len <= LEN_W'(WW)));

endmodule

// File: rtl/tsb_tick.sv
module tsb_tick
    import tsb_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          park,
    input  logic [HW-1:0] half,
    output logic          slot_end,
    output logic          late_half
);

    localparam int CW = HW + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = {half, 1'b0} - CW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (park)
            cnt_q <= last;
        else if (cnt_q >= last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    assign slot_end  = (cnt_q >= last);
    assign late_half = (cnt_q >= {1'b0, half});

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(half) |-> (cnt_q <= last));

endmodule

// File: rtl/tsb_framer.sv
module tsb_framer
    import tsb_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int GW = GAP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_end,
    input  logic             run,
    input  logic             src_pins,
    input  logic [LEN_W-1:0] len,
    input  logic [GW-1:0]    gap,
    input  logic [WW-1:0]    alt_word,
    input  logic [WW-1:0]    par_in,
    output fr_state_e        state,
    output logic             cs_n,
    output logic             sout,
    output logic             frame_done
);

    fr_state_e        state_q;
    logic [WW-1:0]    sh_q;
    logic [LEN_W-1:0] left_q;
    logic [GW-1:0]    gap_q;
    logic             cs_n_q;
    logic             done_q;

    logic [WW-1:0]    pick;
    logic [WW-1:0]    aligned;

    always_comb begin
        pick    = src_pins ? par_in : alt_word;
        aligned = pick << (WW - int'(len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            left_q  <= '0;
            gap_q   <= '0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (slot_end) begin
                case (state_q)
                    ST_IDLE: begin
                        if (run) begin
                            state_q <= ST_SHIFT;
                            sh_q    <= aligned;
                            left_q  <= len - LEN_W'(1);
                            cs_n_q  <= 1'b0;
                        end
                    end
                    ST_SHIFT: begin
                        if (left_q == '0) begin
                            state_q <= ST_GAP;
                            sh_q    <= '0;
                            gap_q   <= gap - GW'(1);
                            cs_n_q  <= 1'b1;
                            done_q  <= 1'b1;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            sh_q   <= {sh_q[WW-2:0], 1'b0};
                        end
                    end
                    ST_GAP: begin
                        if (gap_q != '0) begin
                            gap_q <= gap_q - GW'(1);
                        end else if (run) begin
                            state_q <= ST_SHIFT;
                            sh_q    <= aligned;
                            left_q  <= len - LEN_W'(1);
                            cs_n_q  <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign state      = state_q;
    assign cs_n       = cs_n_q;
    assign sout       = sh_q[WW-1];
    assign frame_done = done_q;

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R13
    done_at_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $rose(cs_n_q));

    // R12
    start_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> $past(run));

    // R6
    cs_on_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> $past(slot_end));

endmodule

// File: rtl/tsb_serializer.sv
module tsb_serializer
    import tsb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    input  logic [WORD_W-1:0]     par_in,
    output logic                  sck,
    output logic                  sout,
    output logic                  cs_n,
    output logic                  frame_done
);

    tsb_cfg_t           cfg;
    logic [WORD_W-1:0]  alt_word;
    fr_state_e          state;
    logic               slot_end;
    logic               late_half;
    logic               park;
    logic               sck_act;

    tsb_regs #(.WW(WORD_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cfg      (cfg),
        .alt_word (alt_word)
    );

    assign park = (state == ST_IDLE) && !cfg.run;

    tsb_tick #(.HW(HALF_W)) tick_i (
        .clk       (clk),
        .rst       (rst),
        .park      (park),
        .half      (cfg.half),
        .slot_end  (slot_end),
        .late_half (late_half)
    );

    tsb_framer #(.WW(WORD_W), .GW(GAP_W)) framer_i (
        .clk        (clk),
        .rst        (rst),
        .slot_end   (slot_end),
        .run        (cfg.run),
        .src_pins   (cfg.src_pins),
        .len        (cfg.len),
        .gap        (cfg.gap),
        .alt_word   (alt_word),
        .par_in     (par_in),
        .state      (state),
        .cs_n       (cs_n),
        .sout       (sout),
        .frame_done (frame_done)
    );

    always_comb begin
        sck_act = late_half &&
                  ((state == ST_SHIFT) || (cfg.cont && (state != ST_IDLE)));
        sck     = cfg.cpol ^ sck_act;
    end

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.cont && cs_n) |-> (sck == cfg.cpol));

    // R7
    cs_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (sck == cfg.cpol));

endmodule

// File: tb/tsb_serializer_tb.sv
module tsb_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [0:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] par_in = '0;
    logic        sck, sout, cs_n, frame_done;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #5 clk = ~clk;

    tsb_serializer dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .par_in     (par_in),
        .sck        (sck),
        .sout       (sout),
        .cs_n       (cs_n),
        .frame_done (frame_done)
    );

    typedef struct packed {
        logic [7:0]  lenf;
        logic [9:0]  gapf;
        logic [9:0]  halff;
        logic        src;
        logic        cont;
        logic        cpol;
        logic [31:0] alt;
        logic [31:0] pins;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd8,  10'd1, 10'd1, 1'b0, 1'b0, 1'b0, 32'hA5A5_F0C3, 32'h0000_0000},
        '{8'd32, 10'd2, 10'd2, 1'b0, 1'b1, 1'b1, 32'h8000_0001, 32'hFFFF_FFFF},
        '{8'd4,  10'd3, 10'd1, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFF0, 32'h1234_567B},
        '{8'd17, 10'd1, 10'd3, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'hDEAD_BEEF},
        '{8'd0,  10'd0, 10'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0009, 32'h0000_0006},
        '{8'd45, 10'd4, 10'd1, 1'b0, 1'b1, 1'b0, 32'hC001_D00D, 32'h0000_0000}
    };

    function automatic int eff_len(input int raw);
        if (raw < 4) return 4;
        if (raw > 32) return 32;
        return raw;
    endfunction

    function automatic int eff_min1(input int raw);
        return (raw == 0) ? 1 : raw;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit run, input bit src, input bit cont,
                                              input bit cpol, input logic [7:0] lenf,
                                              input logic [9:0] gapf, input logic [9:0] halff);
        return {halff, gapf, lenf, cpol, cont, src, run};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [0:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic drain();
        int hi = 0;
        while (hi < 200) begin
            @(negedge clk);
            if (cs_n) hi++;
            else hi = 0;
        end
    endtask

    // Observes one frame starting at (or waiting for) the first low sample of cs_n.
    task automatic observe(input logic [31:0] word, input int len, input int half,
                           input int gap, input bit cont, input bit cpol,
                           input bit meas_gap, input string srcreq);
        logic [31:0] cap = '0;
        logic [31:0] expw;
        int nb = 0, low = 0, high = 0, gedges = 0;
        bit pa, act, stop;
        expw = (len == 32) ? word : (word & ((32'd1 << len) - 32'd1));
        while (cs_n) @(negedge clk);
        low = 1;
        pa  = sck ^ cpol;
        chk(pa == 1'b0, "R7 sck idle when cs_n falls", 32'(sck), 32'(cpol));
        stop = 1'b0;
        while (!stop) begin
            @(negedge clk);
            if (cs_n) begin
                stop = 1'b1;
            end else begin
                low++;
                act = sck ^ cpol;
                if (act && !pa) begin
                    cap = {cap[30:0], sout};
                    nb++;
                end
                pa = act;
            end
        end
        chk(cap == expw, $sformatf("R4 %s frame bits", srcreq), cap, expw);
        chk(nb == len, "R3 bits per frame", 32'(nb), 32'(len));
        chk(low == len * 2 * half, "R6 cs_n low cycles", 32'(low), 32'(len * 2 * half));
        chk(frame_done == 1'b1, "R13 frame_done at cs_n rise", 32'(frame_done), 32'd1);
        chk(sck == cpol, "R11 sck idle level after frame", 32'(sck), 32'(cpol));
        if (meas_gap) begin
            high = 1;
            pa   = sck ^ cpol;
            stop = 1'b0;
            @(negedge clk);
            chk(frame_done == 1'b0, "R13 frame_done one cycle", 32'(frame_done), 32'd0);
            while (!stop) begin
                if (!cs_n || high > 5000) begin
                    stop = 1'b1;
                end else begin
                    high++;
                    act = sck ^ cpol;
                    if (act && !pa) gedges++;
                    pa = act;
                    @(negedge clk);
                end
            end
            chk(high == gap * 2 * half, "R8 gap cycles", 32'(high), 32'(gap * 2 * half));
            if (cont)
                chk(gedges == gap, "R9 sck edges in gap", 32'(gedges), 32'(gap));
            else
                chk(gedges == 0, "R10 sck quiet in gap", 32'(gedges), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n after reset", 32'(cs_n), 32'd1);
        chk(sck == 1'b0, "R1 sck after reset", 32'(sck), 32'd0);
        chk(sout == 1'b0, "R1 sout after reset", 32'(sout), 32'd0);
        chk(frame_done == 1'b0, "R1 frame_done after reset", 32'(frame_done), 32'd0);
        repeat (20) @(negedge clk);
        chk(cs_n == 1'b1, "R1 no frame without run", 32'(cs_n), 32'd1);

        // Vector walk: R2 alternate source, R5 pin source, clamps of R3/R6/R8
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   len, gap, half;
            v    = VECS[i];
            len  = eff_len(int'(v.lenf));
            gap  = eff_min1(int'(v.gapf));
            half = eff_min1(int'(v.halff));
            par_in = v.pins;
            wr(1'b1, v.alt);
            wr(1'b0, ctrl_word(1'b1, v.src, v.cont, v.cpol, v.lenf, v.gapf, v.halff));
            observe(v.src ? v.pins : v.alt, len, half, gap, v.cont, v.cpol, 1'b1,
                    v.src ? "R5" : "R2");
            observe(v.src ? v.pins : v.alt, len, half, gap, v.cont, v.cpol, 1'b0,
                    v.src ? "R5" : "R2");
            wr(1'b0, ctrl_word(1'b0, v.src, v.cont, v.cpol, v.lenf, v.gapf, v.halff));
            drain();
        end

        // R5 snapshot: pins change right after frame start
        par_in = 32'h1357_9BDF;
        wr(1'b0, ctrl_word(1'b1, 1'b1, 1'b0, 1'b0, 8'd32, 10'd2, 10'd1));
        while (cs_n) @(negedge clk);
        par_in = 32'h2468_ACE0;
        observe(32'h1357_9BDF, 32, 1, 2, 1'b0, 1'b0, 1'b1, "R5");
        observe(32'h2468_ACE0, 32, 1, 2, 1'b0, 1'b0, 1'b0, "R5");
        wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b0, 1'b0, 8'd32, 10'd2, 10'd1));
        drain();

        // R12 stop request in the middle of a frame, continuous clock
        begin
            int  edges = 0;
            bit  pa, act, stayed = 1'b1;
            wr(1'b1, 32'h0000_B3C5);
            wr(1'b0, ctrl_word(1'b1, 1'b0, 1'b1, 1'b0, 8'd16, 10'd3, 10'd2));
            observe(32'h0000_B3C5, 16, 2, 3, 1'b1, 1'b0, 1'b1, "R2");
            fork
                observe(32'h0000_B3C5, 16, 2, 3, 1'b1, 1'b0, 1'b0, "R12");
                wr(1'b0, ctrl_word(1'b0, 1'b0, 1'b1, 1'b0, 8'd16, 10'd3, 10'd2));
            join
            pa = sck;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (!cs_n) stayed = 1'b0;
                act = sck;
                if (act && !pa) edges++;
                pa = act;
            end
            chk(stayed, "R12 no frame after stop", 32'(stayed), 32'd1);
            chk(edges == 3, "R12 gap completes then sck stops", 32'(edges), 32'd3);
            chk(sck == 1'b0, "R12 sck idle after stop", 32'(sck), 32'd0);
        end

        report();
    end

endmodule